// File: doc/BRIEF.md
# Drawing Command Packet Framer

The framer sits between a 32-bit drawing-port word stream and a downstream renderer. It reads the opcode in the top byte of the first word of each command, looks up how many words belong to that command, and passes the whole command through with start and end flags. While the words pass, it keeps a shadow of the eight environment registers. Opcodes 0xE0 to 0xE7 store their whole word. Textured primitives carry texture-page bits at a fixed word position. After every command it reloads a 13-bit status field from two of those registers and keeps a sticky flag that says video memory may have been written.

Image-transfer commands (0xA0 for a write into video memory, 0xC0 for a read from it) go to a transfer engine and not to the renderer. The framer takes in the position word, then issues the size word and the position in one strobe with a direction bit. Later, while the engine reports a write still in progress, each word that arrives at a command boundary is pixel data. Such words go to a pixel port and are never parsed. The controller has four states. ST_HEAD waits for a first word. ST_BODY forwards the remaining words. ST_XPOS takes the transfer position and ST_XSIZE takes the transfer size. The transitions are: HEAD→HEAD for a single-word command or a pixel word; HEAD→BODY for a forwarded command longer than one word; BODY→HEAD on its last word; HEAD→XPOS on a transfer opcode; XPOS→XSIZE; XSIZE→HEAD.

Top module: `gpu_cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a command's first word. A forwarded command occupies the table's total word count: 0x02:3, 0x20–23:4, 0x24–27:7, 0x28–2B:5, 0x2C–2F:9, 0x30–33:6, 0x34–37:9, 0x38–3B:8, 0x3C–3F:12, 0x40–43:3, 0x48–4F:4, 0x50–53:4, 0x58–5F:5, 0x60–67:3, 0x68–6B:2, 0x6C–77:3, 0x78–7B:2, 0x7C–7F:3, 0x80:4. Each word appears unchanged on out_data, with out_sop on the first word and out_eop on the last.
- R2: Every opcode not listed in R1 and other than 0xA0/0xC0 is a single-word command, with out_sop and out_eop both high.
- R3: When (opcode & 0xF4) = 0x24, bits 8:0 of word 4 (the first word is word 0) replace bits 8:0 of environment register 1.
- R4: When (opcode & 0xF4) = 0x34, those bits are taken from word 5 instead.
- R5: An opcode with (opcode & 0xF8) = 0xE0 stores its whole word into environment register (opcode & 7). Register k appears on env_flat[32k+31:32k]. All registers reset to zero.
- R6: In the cycle after a command's last word is accepted, status_lo[10:0] equals environment register 1 bits 10:0 and status_lo[12:11] equals register 6 bits 1:0. This includes updates made by that same word.
- R7: vram_dirty is set by any opcode from 0x02 to 0xBF, and it stays set until reset.
- R8: Opcodes 0xA0 and 0xC0 and their two following words are never forwarded. While the size word is on the input, xfer_valid is high with xfer_pos = word 1, xfer_size = word 2 and xfer_read = 1 for 0xC0, 0 for 0xA0.
- R9: While xfer_wr_busy is high at a command boundary, each word appears on pix_data with pix_valid. Such a word is not forwarded and changes no environment register.
- R10: While a word is being forwarded, in_ready equals out_ready. Consumed words (transfer words and pixel words) are accepted whatever out_ready is.
- R11: After reset no output is valid, status_lo is 0 and vram_dirty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_data | input | 32 | Incoming drawing-port word |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Incoming word accepted |
| out_data | output | 32 | Forwarded word to renderer |
| out_valid | output | 1 | Forwarded word valid |
| out_sop | output | 1 | First word of a command |
| out_eop | output | 1 | Last word of a command |
| out_ready | input | 1 | Renderer accepts word |
| xfer_valid | output | 1 | Transfer request strobe |
| xfer_read | output | 1 | 1 = read from video memory, 0 = write |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wr_busy | input | 1 | Engine still expects write pixel words |
| pix_data | output | 32 | Pixel word to transfer engine |
| pix_valid | output | 1 | Pixel word valid |
| env_flat | output | 256 | Eight environment registers, register k at bits 32k+31:32k |
| status_lo | output | 13 | Status field reloaded after each command |
| vram_dirty | output | 1 | Sticky video-memory-written flag |

## Verification
A command's last word can update an environment register in the same cycle that triggers the status reload. This happens with a single-word 0xE1 or 0xE6 command, whose only word is also its last. The bench sends such words, both directed and at random, and checks in the next cycle that the status holds the new value and not the old one. A second overlap is at the boundary after a write transfer. There, a word whose top byte looks like 0xE1 arrives while the engine is busy. The bench checks that it appears on the pixel port and that neither the register nor the status moves.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_BODY  = 2'd1,
        ST_XPOS  = 2'd2,
        ST_XSIZE = 2'd3
    } fr_state_e;

    localparam int OP_W  = 8;
    localparam int LEN_W = 4;

    // total words of a command, first word included
    function automatic logic [LEN_W-1:0] pkt_total_len(input logic [OP_W-1:0] op);
        logic [LEN_W-1:0] n;
        case (op) inside
            8'h02:              n = 4'd3;
            [8'h20:8'h23]:      n = 4'd4;
            [8'h24:8'h27]:      n = 4'd7;
            [8'h28:8'h2B]:      n = 4'd5;
            [8'h2C:8'h2F]:      n = 4'd9;
            [8'h30:8'h33]:      n = 4'd6;
            [8'h34:8'h37]:      n = 4'd9;
            [8'h38:8'h3B]:      n = 4'd8;
            [8'h3C:8'h3F]:      n = 4'd12;
            [8'h40:8'h43]:      n = 4'd3;
            [8'h48:8'h4F]:      n = 4'd4;
            [8'h50:8'h53]:      n = 4'd4;
            [8'h58:8'h5F]:      n = 4'd5;
            [8'h60:8'h67]:      n = 4'd3;
            [8'h68:8'h6B]:      n = 4'd2;
            [8'h6C:8'h77]:      n = 4'd3;
            [8'h78:8'h7B]:      n = 4'd2;
            [8'h7C:8'h7F]:      n = 4'd3;
            8'h80:              n = 4'd4;
            8'hA0, 8'hC0:       n = 4'd3;
            default:            n = 4'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
    import gcf_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    output logic [LEN_W-1:0] total_len,
    output logic             is_xfer,
    output logic             is_env,
    output logic             is_tex,
    output logic [LEN_W-1:0] tex_word,
    output logic             marks_dirty
);
    always_comb begin
        total_len   = pkt_total_len(op);
        is_xfer     = (op == 8'hA0) || (op == 8'hC0);
        is_env      = (op[7:3] == 5'b11100);
        marks_dirty = (op >= 8'h02) && (op <= 8'hBF);
        is_tex      = 1'b0;
        tex_word    = '0;
        if ((op & 8'hF4) == 8'h24) begin
            is_tex   = 1'b1;
            tex_word = 4'd4;
        end else if ((op & 8'hF4) == 8'h34) begin
            is_tex   = 1'b1;
            tex_word = 4'd5;
        end
    end
endmodule

// File: rtl/env_shadow.sv
module env_shadow #(
    parameter int DW      = 32,
    parameter int ENV_CNT = 8,
    parameter int TP_W    = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       full_we,
    input  logic [$clog2(ENV_CNT)-1:0] full_idx,
    input  logic [DW-1:0]              full_data,
    input  logic                       tp_we,
    input  logic [TP_W-1:0]            tp_bits,
    input  logic                       pkt_done,
    input  logic                       dirty_set,
    output logic [ENV_CNT*DW-1:0]      env_flat,
    output logic [12:0]                status_lo,
    output logic                       vram_dirty
);
    logic [DW-1:0] env_q [ENV_CNT];
    logic [DW-1:0] env_d [ENV_CNT];

    always_comb begin
        for (int k = 0; k < ENV_CNT; k++) env_d[k] = env_q[k];
        if (tp_we)   env_d[1][TP_W-1:0] = tp_bits;
        if (full_we) env_d[full_idx]    = full_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ENV_CNT; k++) env_q[k] <= '0;
            status_lo  <= '0;
            vram_dirty <= 1'b0;
        end else begin
            for (int k = 0; k < ENV_CNT; k++) env_q[k] <= env_d[k];
            if (pkt_done)  status_lo  <= {env_d[6][1:0], env_d[1][10:0]};
            if (dirty_set) vram_dirty <= 1'b1;
        end
    end

    for (genvar g = 0; g < ENV_CNT; g++) begin : g_flat
        assign env_flat[g*DW +: DW] = env_q[g];
    end
endmodule

// File: rtl/gpu_cmd_framer.sv
module gpu_cmd_framer
    import gcf_pkg::*;
#(
    parameter int DW      = 32,
    parameter int ENV_CNT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         in_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    output logic [DW-1:0]         out_data,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic                  out_eop,
    input  logic                  out_ready,
    output logic                  xfer_valid,
    output logic                  xfer_read,
    output logic [DW-1:0]         xfer_pos,
    output logic [DW-1:0]         xfer_size,
    input  logic                  xfer_wr_busy,
    output logic [DW-1:0]         pix_data,
    output logic                  pix_valid,
    output logic [ENV_CNT*DW-1:0] env_flat,
    output logic [12:0]           status_lo,
    output logic                  vram_dirty
);
    localparam int IDX_W = $clog2(ENV_CNT);

    fr_state_e        state_q, state_d;
    logic [OP_W-1:0]  op_q;
    logic [LEN_W-1:0] len_q, idx_q;
    logic [DW-1:0]    pos_q;
    logic             dir_q;

    logic [OP_W-1:0]  head_op, dec_op;
    logic [LEN_W-1:0] d_len, d_texw;
    logic             d_xfer, d_env, d_tex, d_dirty;
    logic             at_head, pix_mode, fwd, acc;

    assign head_op = in_data[DW-1 -: OP_W];
    assign at_head = (state_q == ST_HEAD);
    assign dec_op  = at_head ? head_op : op_q;

    cmd_len_decode u_dec (
        .op          (dec_op),
        .total_len   (d_len),
        .is_xfer     (d_xfer),
        .is_env      (d_env),
        .is_tex      (d_tex),
        .tex_word    (d_texw),
        .marks_dirty (d_dirty)
    );

    // output / handshake process
    always_comb begin
        pix_mode   = at_head && xfer_wr_busy;
        fwd        = (at_head && !xfer_wr_busy && !d_xfer) || (state_q == ST_BODY);
        in_ready   = fwd ? out_ready : 1'b1;
        acc        = in_valid && in_ready;
        out_data   = in_data;
        out_valid  = in_valid && fwd;
        out_sop    = at_head;
        out_eop    = at_head ? (d_len == 4'd1) : (idx_q == len_q - 4'd1);
        pix_data   = in_data;
        pix_valid  = in_valid && pix_mode;
        xfer_valid = in_valid && (state_q == ST_XSIZE);
        xfer_pos   = pos_q;
        xfer_size  = in_data;
        xfer_read  = dir_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEAD: if (acc && !pix_mode) begin
                if (d_xfer)             state_d = ST_XPOS;
                else if (d_len != 4'd1) state_d = ST_BODY;
            end
            ST_BODY:  if (acc && out_eop) state_d = ST_HEAD;
            ST_XPOS:  if (acc)            state_d = ST_XSIZE;
            ST_XSIZE: if (acc)            state_d = ST_HEAD;
            default:                      state_d = ST_HEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HEAD;
        else        state_q <= state_d;
    end

    // command context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            len_q <= '0;
            idx_q <= '0;
            pos_q <= '0;
            dir_q <= 1'b0;
        end else if (acc) begin
            if (at_head && !pix_mode) begin
                op_q  <= head_op;
                len_q <= d_len;
                idx_q <= 4'd1;
                dir_q <= (head_op == 8'hC0);
            end else if (state_q == ST_BODY) begin
                idx_q <= idx_q + 4'd1;
            end else if (state_q == ST_XPOS) begin
                pos_q <= in_data;
            end
        end
    end

    env_shadow #(.DW(DW), .ENV_CNT(ENV_CNT), .TP_W(9)) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_we   (acc && at_head && !pix_mode && d_env),
        .full_idx  (head_op[IDX_W-1:0]),
        .full_data (in_data),
        .tp_we     (acc && (state_q == ST_BODY) && d_tex && (idx_q == d_texw)),
        .tp_bits   (in_data[8:0]),
        .pkt_done  (acc && ((fwd && out_eop) || (state_q == ST_XSIZE))),
        .dirty_set (acc && at_head && !pix_mode && d_dirty),
        .env_flat  (env_flat),
        .status_lo (status_lo),
        .vram_dirty(vram_dirty)
    );
endmodule

// File: rtl/gcf_checker.sv
module gcf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_eop,
    input logic        xfer_valid,
    input logic        pix_valid,
    input logic [12:0] status_lo,
    input logic [10:0] env1_lo,
    input logic [1:0]  env6_lo,
    input logic        vram_dirty
);
    // R1
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    // R8
    xfer_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !out_valid);

    // R9
    pix_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (!out_valid && !xfer_valid));

    // R10
    fwd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));

    // R7
    dirty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_dirty |=> vram_dirty);

    // R6
    status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> (status_lo == {env6_lo, env1_lo}));
endmodule

bind gpu_cmd_framer gcf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_eop    (out_eop),
    .xfer_valid (xfer_valid),
    .pix_valid  (pix_valid),
    .status_lo  (status_lo),
    .env1_lo    (env_flat[DW+10 : DW]),
    .env6_lo    (env_flat[6*DW+1 : 6*DW]),
    .vram_dirty (vram_dirty)
);

// File: tb/sim_gpu_cmd_framer.sv
module sim_gpu_cmd_framer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [31:0]  in_data;
    logic         in_valid, in_ready;
    logic [31:0]  out_data;
    logic         out_valid, out_sop, out_eop, out_ready;
    logic         xfer_valid, xfer_read;
    logic [31:0]  xfer_pos, xfer_size;
    logic         xfer_wr_busy;
    logic [31:0]  pix_data;
    logic         pix_valid;
    logic [255:0] env_flat;
    logic [12:0]  status_lo;
    logic         vram_dirty;

    always #4 clk = ~clk;

    gpu_cmd_framer u0 (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] m_env [8];
    logic [12:0] m_stat;
    logic        m_dirty;
    int          b_mode;   // 0 head, 1 body, 2 position, 3 size
    logic [7:0]  b_op;
    int          b_idx, b_len, pix_left;
    logic [31:0] b_pos;

    function automatic int exp_len(input logic [7:0] op);
        if (op == 8'h02) return 3;
        if (op >= 8'h20 && op <= 8'h23) return 4;
        if (op >= 8'h24 && op <= 8'h27) return 7;
        if (op >= 8'h28 && op <= 8'h2B) return 5;
        if (op >= 8'h2C && op <= 8'h2F) return 9;
        if (op >= 8'h30 && op <= 8'h33) return 6;
        if (op >= 8'h34 && op <= 8'h37) return 9;
        if (op >= 8'h38 && op <= 8'h3B) return 8;
        if (op >= 8'h3C && op <= 8'h3F) return 12;
        if (op >= 8'h40 && op <= 8'h43) return 3;
        if (op >= 8'h48 && op <= 8'h53) return 4;
        if (op >= 8'h58 && op <= 8'h5F) return 5;
        if (op >= 8'h60 && op <= 8'h67) return 3;
        if (op >= 8'h68 && op <= 8'h6B) return 2;
        if (op >= 8'h6C && op <= 8'h77) return 3;
        if (op >= 8'h78 && op <= 8'h7B) return 2;
        if (op >= 8'h7C && op <= 8'h7F) return 3;
        if (op == 8'h80) return 4;
        if (op == 8'hA0 || op == 8'hC0) return 3;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_state();
        for (int k = 0; k < 8; k++)
            chk(env_flat[k*32 +: 32] == m_env[k], "R3 R4 R5 environment register",
                {32'd0, env_flat[k*32 +: 32]}, {32'd0, m_env[k]});
        chk(status_lo == m_stat, "R6 status reload", {51'd0, status_lo}, {51'd0, m_stat});
        chk(vram_dirty == m_dirty, "R7 dirty flag", {63'd0, vram_dirty}, {63'd0, m_dirty});
    endtask

    // drive one word at a negedge, check, accept it, update the model
    task automatic put(input logic [31:0] w, input int stall);
        bit fwd, pix, done, xop;
        logic [7:0] op;
        int len;
        op  = w[31:24];
        len = exp_len(op);
        xop = (op == 8'hA0) || (op == 8'hC0);
        pix = (pix_left > 0);
        fwd = !pix && ((b_mode == 0 && !xop) || b_mode == 1);
        in_data   = w;
        in_valid  = 1'b1;
        out_ready = (stall == 0);
        #1;
        if (stall > 0) begin
            chk(in_ready == !fwd, "R10 in_ready with renderer stalled", {63'd0, in_ready}, {63'd0, !fwd});
            if (fwd) begin
                repeat (stall) @(negedge clk);
                out_ready = 1'b1;
                #1;
            end
        end
        if (pix) begin
            chk(pix_valid && !out_valid && pix_data == w, "R9 pixel routing",
                {pix_valid, out_valid, pix_data}, {1'b1, 1'b0, w});
        end else begin
            case (b_mode)
                0: if (xop)
                        chk(!out_valid && in_ready && !xfer_valid, "R8 transfer header consumed",
                            {out_valid, in_ready, xfer_valid}, {1'b0, 1'b1, 1'b0});
                   else if (len == 1)
                        chk(out_valid && out_sop && out_eop && out_data == w, "R2 single-word command",
                            {out_valid, out_sop, out_eop, out_data}, {3'b111, w});
                   else
                        chk(out_valid && out_sop && !out_eop && out_data == w, "R1 command head",
                            {out_valid, out_sop, out_eop, out_data}, {3'b110, w});
                1: chk(out_valid && !out_sop && out_eop == (b_idx == b_len - 1) && out_data == w,
                       "R1 command body", {out_valid, out_sop, out_eop, out_data},
                       {1'b1, 1'b0, (b_idx == b_len - 1), w});
                2: chk(!out_valid && !xfer_valid, "R8 position word consumed",
                       {out_valid, xfer_valid}, 2'b00);
                default: chk(xfer_valid && !out_valid && xfer_read == (b_op == 8'hC0) &&
                             xfer_pos == b_pos && xfer_size == w, "R8 transfer issue",
                             {xfer_valid, xfer_read, xfer_pos, xfer_size[29:0]},
                             {1'b1, (b_op == 8'hC0), b_pos, w[29:0]});
            endcase
        end
        @(posedge clk);
        done = 0;
        if (pix) begin
            pix_left--;
            if (pix_left == 0) done = 1;
        end else begin
            case (b_mode)
                0: begin
                    b_op = op; b_len = len; b_idx = 1;
                    if (op >= 8'h02 && op <= 8'hBF) m_dirty = 1'b1;
                    if (op[7:3] == 5'b11100) m_env[op[2:0]] = w;
                    if (xop) b_mode = 2;
                    else if (len == 1) done = 1;
                    else b_mode = 1;
                end
                1: begin
                    if (b_idx == 4 && (b_op & 8'hF4) == 8'h24) m_env[1][8:0] = w[8:0];
                    if (b_idx == 5 && (b_op & 8'hF4) == 8'h34) m_env[1][8:0] = w[8:0];
                    if (b_idx == b_len - 1) begin done = 1; b_mode = 0; end
                    else b_idx++;
                end
                2: begin b_pos = w; b_mode = 3; end
                default: begin
                    b_mode = 0; done = 1;
                    if (b_op == 8'hA0) pix_left = (w[15:0] * w[31:16] + 1) / 2;
                end
            endcase
            if (done) m_stat = {m_env[6][1:0], m_env[1][10:0]};
        end
        @(negedge clk);
        in_valid     = 1'b0;
        xfer_wr_busy = (pix_left > 0);
        if (done) chk_state();
    endtask

    task automatic send_cmd(input logic [7:0] op, input int stall_pct);
        int len;
        logic [31:0] w;
        len = exp_len(op);
        for (int k = 0; k < len; k++) begin
            w = $urandom();
            if (k == 0) w[31:24] = op;
            put(w, ($urandom_range(0, 99) < stall_pct) ? $urandom_range(1, 2) : 0);
        end
    endtask

    task automatic send_xfer(input logic [7:0] op, input logic [15:0] wdt, input logic [15:0] hgt);
        put({op, 24'h00_1234}, 1);
        put($urandom(), 0);
        put({hgt, wdt}, 0);
        while (pix_left > 0) put(32'hE1FF_FFFF ^ {8'd0, 24'($urandom())}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] op;
        void'($urandom(32'd5150));
        for (int k = 0; k < 8; k++) m_env[k] = '0;
        m_stat = '0; m_dirty = 0; b_mode = 0; pix_left = 0;
        b_op = '0; b_idx = 0; b_len = 0; b_pos = '0;
        rst_n = 0; in_valid = 0; in_data = '0; out_ready = 1; xfer_wr_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!out_valid && !xfer_valid && !pix_valid, "R11 no output after reset",
            {out_valid, xfer_valid, pix_valid}, 3'b000);
        chk_state();

        // status reload in the same cycle as a register write
        put(32'hE100_07AB, 0);
        put(32'hE600_0002, 1);
        put(32'hE100_0155, 0);
        chk(status_lo == 13'h1155, "R6 same-cycle reload", {51'd0, status_lo}, 64'h1155);

        // R2 unlisted opcode and no-dirty opcode
        put(32'h0000_0000, 0);
        chk(vram_dirty == 1'b0, "R7 opcode 0x00 leaves dirty clear", {63'd0, vram_dirty}, 64'd0);
        put(32'h4400_0000, 0);
        chk(vram_dirty == 1'b1, "R7 opcode 0x44 sets dirty", {63'd0, vram_dirty}, 64'd1);

        // R3 R4 textured snoops
        send_cmd(8'h24, 30);
        send_cmd(8'h2F, 30);
        send_cmd(8'h34, 30);
        send_cmd(8'h3E, 30);

        // R8 R9 transfers
        send_xfer(8'hA0, 16'd3, 16'd3);
        send_xfer(8'hC0, 16'd2, 16'd2);
        send_cmd(8'h02, 0);
        send_xfer(8'hA0, 16'd1, 16'd1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            op = 8'($urandom_range(0, 255));
            if (op == 8'hA0 || op == 8'hC0) op = 8'hE6;
            if (n % 50 == 49) send_xfer(($urandom_range(0, 1) == 1) ? 8'hA0 : 8'hC0,
                                        16'($urandom_range(1, 4)), 16'($urandom_range(1, 3)));
            else send_cmd(op, 25);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule